// File: doc/BRIEF.md
# UART Transmitter with Holding Buffer

This block serialises characters onto a single asynchronous line. A bus-side write port loads a one-character holding register. While the shift register is free, the character moves into it one cycle later, so the holding register can take the next character while the current frame is still going out. Frames therefore follow each other with no idle bit between them. The bit rate comes from an external 16x tick, and a free-running modulo-16 counter divides it down to bit boundaries.

A 3-bit mode input chooses the data field. It can be 7 data bits with parity, 8 plain data bits, 9 data bits, 8 data bits with parity, or 8 data bits with a wake-up flag. A second input selects one or two stop bits, and a third selects even or odd parity. Two single-cycle events support the driver software:
- The buffer-free event fires when a character leaves the holding register.
- The frame-end event fires as the final stop bit goes onto the line, so a following character can be queued before the frame has fully ended.

Top module: `utx_core`

## Requirements
- R1: During and after a synchronous active-low reset, the line is 1, both events are 0, the holding readback is zero and the collision flag is 0.
- R2: A frame is one 0 start bit, then the data field least significant bit first, then stop bits of 1. There is one stop bit when `two_stop`=0 and two when `two_stop`=1. Each bit lasts one full counter period, which is 16 ticks.
- R3: The mode codes set the data field as follows:
  - 3'b011: data bits 6..0, then parity, for an 8-bit field.
  - 3'b100: data bits 8..0.
  - 3'b101: data bits 7..0, then the wake-up flag taken from written bit 8.
  - 3'b111: data bits 7..0, then parity.
  - Every other code: data bits 7..0 with no ninth bit.
- R4: Even parity (`odd_parity`=0) sends 1 when the XOR of the data bits is 1. Odd parity sends the inverse.
- R5: The line only changes on an overflow of the modulo-16 tick counter, which occurs on the 16th tick counted since `run_en` rose. While `run_en` is 0, the counter is held at zero and no frame starts.
- R6: A character written while the shifter is free moves into the shifter on the next clock, with a one-cycle `buf_free_evt`. A character written while a frame is being sent starts on the overflow that ends the previous frame, with no idle gap.
- R7: `frame_end_evt` pulses for one cycle in the clock where the last stop bit is first driven onto the line.
- R8: When written, the holding register keeps only the bits that the mode in force uses: 7 for 3'b011, 9 for 3'b100 and 3'b101, and 8 otherwise. It reads back zero once its character has moved into the shifter.
- R9: The line holds 1 whenever no frame is being sent.
- R10: A write while the holding register is full, and not being emptied in that cycle, replaces the pending character and sets `wr_collision`. The flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run_en | input | 1 | Bit-rate counter run control |
| tick16 | input | 1 | Tick at 16 times the bit rate |
| mode | input | 3 | Frame mode code |
| two_stop | input | 1 | 1 selects two stop bits |
| odd_parity | input | 1 | 1 selects odd parity |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 9 | Character to send |
| txd | output | 1 | Serial output line |
| buf_free_evt | output | 1 | Pulse when the holding register is handed to the shifter |
| frame_end_evt | output | 1 | Pulse as the last stop bit starts |
| hold_rd | output | 9 | Holding register readback |
| wr_collision | output | 1 | Sticky flag for a write that overwrote a pending character |

## Verification
Single frames are sent in every mode code with each stop count and parity sense, using random data. This separates errors in field width, parity position and parity polarity.

Bursts of two or three characters, each written while the previous frame is still shifting, show whether the handoff is gapless. They are checked by the exact distance between successive start edges and by where the frame-end pulse falls.

A write made while the counter is stopped shows that nothing leaves before an overflow. A triple write into a busy block tells an overwrite apart from a dropped or duplicated character.

// File: rtl/utx_pkg.sv
// Package: shared sizes, mode codes and frame construction for the
// UART transmitter. Assumes at most 9 written bits and 2 stop bits.
package utx_pkg;

    localparam int DATA_W  = 9;
    localparam int FRAME_W = 12;   // start + 9 field bits + 2 stops
    localparam int LEN_W   = 4;

    localparam logic [2:0] MODE_P7   = 3'b011;
    localparam logic [2:0] MODE_D9   = 3'b100;
    localparam logic [2:0] MODE_WAKE = 3'b101;
    localparam logic [2:0] MODE_P8   = 3'b111;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;  // bit 0 goes out first
        logic [LEN_W-1:0]   len;   // number of bit times in the frame
    } frame_t;

    // Keep only the bits the mode transmits.
    function automatic logic [DATA_W-1:0] mask_data(input logic [2:0] m,
                                                    input logic [DATA_W-1:0] d);
        logic [DATA_W-1:0] r;
        case (m)
            MODE_P7:            r = d & 9'h07F;
            MODE_D9, MODE_WAKE: r = d;
            default:            r = d & 9'h0FF;
        endcase
        return r;
    endfunction

    // Build the bit sequence and length of one frame.
    function automatic frame_t build_frame(input logic [2:0] m,
                                           input logic s2,
                                           input logic od,
                                           input logic [DATA_W-1:0] d);
        frame_t f;
        int     nf;
        f.bits    = '1;
        f.bits[0] = 1'b0;
        case (m)
            MODE_P7: begin
                f.bits[7:1] = d[6:0];
                f.bits[8]   = (^d[6:0]) ^ od;
                nf = 8;
            end
            MODE_D9, MODE_WAKE: begin
                f.bits[9:1] = d;
                nf = 9;
            end
            MODE_P8: begin
                f.bits[8:1] = d[7:0];
                f.bits[9]   = (^d[7:0]) ^ od;
                nf = 9;
            end
            default: begin
                f.bits[8:1] = d[7:0];
                nf = 8;
            end
        endcase
        f.len = LEN_W'(1 + nf + (s2 ? 2 : 1));
        return f;
    endfunction

endpackage

// File: rtl/utx_baud16.sv
// Bit-rate divider: counts 16x ticks modulo OVS and flags the overflow.
// Assumes tick is a single-cycle strobe; counter held at zero while stopped.
module utx_baud16 #(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic tick,
    output logic ovf
);
    localparam int CW = $clog2(OVS);
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);

    logic [CW-1:0] cnt;

    assign ovf = run_en && tick && (cnt == LAST);

    // Free-running tick counter, cleared while the run control is low.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/utx_hold.sv
// Holding register: captures masked writes, empties when the shifter
// takes it, flags overwrites of a pending character. Assumes take only
// asserts while full.
module utx_hold (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [2:0]                 mode,
    input  logic                       wr_en,
    input  logic [utx_pkg::DATA_W-1:0] wr_data,
    input  logic                       take,
    output logic [utx_pkg::DATA_W-1:0] hold_q,
    output logic                       hold_full,
    output logic                       collide
);

    // Write, hand-off and collision tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q    <= '0;
            hold_full <= 1'b0;
            collide   <= 1'b0;
        end else if (wr_en) begin
            hold_q    <= utx_pkg::mask_data(mode, wr_data);
            hold_full <= 1'b1;
            if (hold_full && !take) collide <= 1'b1;
        end else if (take) begin
            hold_q    <= '0;
            hold_full <= 1'b0;
        end
    end

    // R10: the collision flag never clears outside reset
    a_r10_collision_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        collide |=> collide);

    // R8: a hand-off without a new write leaves the readback at zero
    a_r8_cleared_on_take: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(take) && !$past(wr_en)) |-> (hold_q == '0));

endmodule

// File: rtl/utx_shifter.sv
// Frame shifter: loads a built frame, starts it on a counter overflow and
// emits one bit per overflow. Raises the hand-off and last-stop events.
// Assumes frame_in is stable while hold_full and frames are >= 10 bits.
module utx_shifter (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ovf,
    input  logic              hold_full,
    input  utx_pkg::frame_t   frame_in,
    output logic              take,
    output logic              txd,
    output logic              empty_evt,
    output logic              done_evt
);
    import utx_pkg::*;

    typedef enum logic [1:0] {S_IDLE, S_PEND, S_SEND} state_t;

    state_t             state;
    logic [FRAME_W-1:0] sh;
    logic [LEN_W-1:0]   left;
    logic               sh_free;

    assign sh_free = (state == S_IDLE) || ((state == S_SEND) && (left == '0));
    assign take    = hold_full && sh_free;

    // Frame sequencing, line drive and event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            sh        <= '0;
            left      <= '0;
            txd       <= 1'b1;
            empty_evt <= 1'b0;
            done_evt  <= 1'b0;
        end else begin
            empty_evt <= 1'b0;
            done_evt  <= 1'b0;
            if (take) begin
                empty_evt <= 1'b1;
                if (ovf) begin
                    txd   <= frame_in.bits[0];
                    sh    <= frame_in.bits >> 1;
                    left  <= frame_in.len - LEN_W'(1);
                    state <= S_SEND;
                end else begin
                    sh    <= frame_in.bits;
                    left  <= frame_in.len;
                    state <= S_PEND;
                end
            end else if (ovf) begin
                case (state)
                    S_PEND: begin
                        txd   <= sh[0];
                        sh    <= sh >> 1;
                        left  <= left - LEN_W'(1);
                        state <= S_SEND;
                    end
                    S_SEND: begin
                        if (left != '0) begin
                            txd  <= sh[0];
                            sh   <= sh >> 1;
                            left <= left - LEN_W'(1);
                            if (left == LEN_W'(1)) done_evt <= 1'b1;
                        end else begin
                            state <= S_IDLE;
                        end
                    end
                    default: txd <= 1'b1;
                endcase
            end
        end
    end

    // R9: the line rests high outside an active frame
    a_r9_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_SEND) |-> txd);

    // R7: the frame-end event is a single-cycle pulse
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |=> !done_evt);

    // R5: the line only moves on a counter overflow
    a_r5_moves_on_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(txd) |-> $past(ovf));

endmodule

// File: rtl/utx_core.sv
// UART transmitter top: holding register, bit-rate counter and frame
// shifter. Assumes tick16 is a one-cycle strobe at 16x the bit rate and
// that mode, stop and parity controls are steady while characters are queued.
module utx_core #(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_en,
    input  logic       tick16,
    input  logic [2:0] mode,
    input  logic       two_stop,
    input  logic       odd_parity,
    input  logic       wr_en,
    input  logic [8:0] wr_data,
    output logic       txd,
    output logic       buf_free_evt,
    output logic       frame_end_evt,
    output logic [8:0] hold_rd,
    output logic       wr_collision
);

    logic            ovf;
    logic            take;
    logic            hold_full;
    utx_pkg::frame_t frame;

    utx_baud16 #(.OVS(OVS)) u_baud (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_en (run_en),
        .tick   (tick16),
        .ovf    (ovf)
    );

    utx_hold u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .take      (take),
        .hold_q    (hold_rd),
        .hold_full (hold_full),
        .collide   (wr_collision)
    );

    // Frame image built from the pending character and current controls.
    always_comb begin
        frame = utx_pkg::build_frame(mode, two_stop, odd_parity, hold_rd);
    end

    utx_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .ovf       (ovf),
        .hold_full (hold_full),
        .frame_in  (frame),
        .take      (take),
        .txd       (txd),
        .empty_evt (buf_free_evt),
        .done_evt  (frame_end_evt)
    );

endmodule

// File: tb/utx_core_bench.sv
`timescale 1ns/1ps
// Bench for utx_core: decodes the serial line at 32 clocks per bit
// (a tick every second clock) and compares each frame with a bench model.
module utx_core_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0;
    logic       tick16 = 1'b0;
    logic [2:0] mode = 3'b001;
    logic       two_stop = 1'b0;
    logic       odd_parity = 1'b0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic       txd;
    logic       buf_free_evt;
    logic       frame_end_evt;
    logic [8:0] hold_rd;
    logic       wr_collision;

    always #4 clk = ~clk;

    utx_core u_utx_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .run_en        (run_en),
        .tick16        (tick16),
        .mode          (mode),
        .two_stop      (two_stop),
        .odd_parity    (odd_parity),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .txd           (txd),
        .buf_free_evt  (buf_free_evt),
        .frame_end_evt (frame_end_evt),
        .hold_rd       (hold_rd),
        .wr_collision  (wr_collision)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int run_ticks = 0;
    int free_cnt = 0;
    bit mon_busy = 1'b0;

    logic [11:0] q_bits[$];
    int          q_len[$];
    bit          q_b2b[$];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [8:0] bmask(input logic [2:0] m, input logic [8:0] d);
        if (m == 3'b011) return d & 9'h07F;
        if (m == 3'b100 || m == 3'b101) return d;
        return d & 9'h0FF;
    endfunction

    function automatic void exp_frame(input logic [2:0] m, input bit s2, input bit od,
                                      input logic [8:0] d,
                                      output logic [11:0] bits, output int len);
        logic [8:0] fld;
        int nf;
        case (m)
            3'b011:         begin nf = 8; fld = {1'b0, (^d[6:0]) ^ od, d[6:0]}; end
            3'b100, 3'b101: begin nf = 9; fld = d; end
            3'b111:         begin nf = 9; fld = {(^d[7:0]) ^ od, d[7:0]}; end
            default:        begin nf = 8; fld = {1'b0, d[7:0]}; end
        endcase
        bits = '1;
        bits[0] = 1'b0;
        for (int i = 0; i < nf; i++) bits[1 + i] = fld[i];
        len = 1 + nf + (s2 ? 2 : 1);
    endfunction

    // Tick strobe every second clock, driven away from the active edge.
    initial begin
        forever begin
            @(negedge clk);
            tick16 = ~tick16;
        end
    end

    // Cycle, tick-since-run and buffer-free counters.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n || !run_en) run_ticks <= 0;
        else if (tick16) run_ticks <= run_ticks + 1;
    end

    always @(negedge clk) if (buf_free_evt) free_cnt <= free_cnt + 1;

    // Line decoder.
    initial begin
        bit          prev_txd;
        int          prev_start;
        int          prev_len;
        logic [11:0] eb;
        logic [11:0] got;
        int          el;
        bit          eb2b;
        int          done_off;
        prev_txd = 1'b1;
        prev_start = 0;
        prev_len = 0;
        forever begin
            @(negedge clk);
            if (rst_n && prev_txd && !txd) begin
                mon_busy = 1'b1;
                // R5: start edge sits on a 16-tick boundary since run began
                check((run_ticks % 16 == 0) && (run_ticks > 0), "R5",
                      "start phase", run_ticks % 16, 0);
                if (q_len.size() == 0) begin
                    check(1'b0, "R2", "unexpected frame", 1, 0);
                    eb = '1; el = 10; eb2b = 1'b0;
                end else begin
                    eb = q_bits.pop_front();
                    el = q_len.pop_front();
                    eb2b = q_b2b.pop_front();
                end
                // R6: queued character follows with no idle gap
                if (eb2b)
                    check(cyc - prev_start == prev_len * 32, "R6", "gap clocks",
                          cyc - prev_start, prev_len * 32);
                prev_start = cyc;
                prev_len = el;
                got = '1;
                done_off = -1;
                for (int off = 1; off < el * 32; off++) begin
                    @(negedge clk);
                    if (off >= 16 && ((off - 16) % 32) == 0) got[(off - 16) / 32] = txd;
                    if (frame_end_evt) done_off = off;
                end
                // R2 R3 R4: bit-exact frame, field layout and parity
                check(got == eb, "R2 R3 R4", "frame bits", int'(got), int'(eb));
                // R7: frame-end pulse at the start of the final stop bit
                check(done_off == (el - 1) * 32, "R7", "frame end offset",
                      done_off, (el - 1) * 32);
                prev_txd = txd;
                mon_busy = 1'b0;
            end else begin
                prev_txd = txd;
            end
        end
    end

    task automatic push_exp(input logic [8:0] d, input bit b2b);
        logic [11:0] b;
        int l;
        exp_frame(mode, two_stop, odd_parity, bmask(mode, d), b, l);
        q_bits.push_back(b);
        q_len.push_back(l);
        q_b2b.push_back(b2b);
    endtask

    task automatic wr_raw(input logic [8:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr(input logic [8:0] d, input bit b2b);
        push_exp(d, b2b);
        wr_raw(d);
    endtask

    task automatic wait_free(input int target);
        while (free_cnt < target) @(negedge clk);
    endtask

    task automatic wait_done();
        while (q_len.size() != 0 || mon_busy) @(negedge clk);
        repeat (40) @(negedge clk);
    endtask

    task automatic check_reset_state();
        check(txd == 1'b1, "R1", "txd", txd, 1);
        check(!buf_free_evt && !frame_end_evt, "R1", "events",
              {buf_free_evt, frame_end_evt}, 0);
        check(hold_rd == 9'h0, "R1", "hold readback", hold_rd, 0);
        check(wr_collision == 1'b0, "R1", "collision", wr_collision, 0);
    endtask

    // Watchdog: a hang counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R2 watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [2:0] modes[5];
        int base;
        int burst;
        modes = '{3'b011, 3'b100, 3'b101, 3'b111, 3'b001};
        void'($urandom(32'h5EED));

        // R1: reset state
        repeat (5) @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_reset_state();

        // R5 R6: write while stopped; hand-off happens, line stays high
        base = free_cnt;
        mode = 3'b001;
        wr(9'h0A5, 1'b0);
        repeat (300) @(negedge clk);
        check(txd == 1'b1, "R5", "line while stopped", txd, 1);
        check(free_cnt == base + 1, "R6", "buffer free pulses", free_cnt - base, 1);
        run_en = 1'b1;
        wait_done();

        // R3 R4: every mode with both stop counts and both parity senses
        foreach (modes[i]) begin
            for (int s = 0; s < 2; s++) begin
                for (int p = 0; p < 2; p++) begin
                    mode = modes[i];
                    two_stop = s[0];
                    odd_parity = p[0];
                    wr(9'($urandom), 1'b0);
                    wait_done();
                end
            end
        end

        // R6 R8: back-to-back pair with masking in 7+parity mode
        mode = 3'b011; two_stop = 1'b1; odd_parity = 1'b0;
        base = free_cnt;
        wr(9'h055, 1'b0);
        wait_free(base + 1);
        wr(9'h1FF, 1'b1);
        check(hold_rd == 9'h07F, "R8", "masked pending char", hold_rd, 9'h07F);
        wait_free(base + 2);
        @(negedge clk);
        check(hold_rd == 9'h000, "R8", "readback after hand-off", hold_rd, 0);
        wait_done();

        // R9: line rests high between frames
        check(txd == 1'b1, "R9", "line idle", txd, 1);

        // R10: overwrite of a pending character
        mode = 3'b100; two_stop = 1'b0;
        base = free_cnt;
        wr(9'h123, 1'b0);
        wait_free(base + 1);
        wr_raw(9'h0F0);
        wr(9'h1C3, 1'b1);
        check(wr_collision == 1'b1, "R10", "collision flag", wr_collision, 1);
        check(hold_rd == 9'h1C3, "R10", "overwritten char", hold_rd, 9'h1C3);
        wait_done();
        check(wr_collision == 1'b1, "R10", "flag sticky", wr_collision, 1);

        // R1: reset clears the sticky flag
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // Random bursts of one to three characters per configuration.
        for (int n = 0; n < 25; n++) begin
            mode = modes[$urandom % 5];
            two_stop = 1'($urandom);
            odd_parity = 1'($urandom);
            burst = 1 + ($urandom % 3);
            for (int k = 0; k < burst; k++) begin
                base = free_cnt;
                wr(9'($urandom), k != 0);
                wait_free(base + 1);
            end
            wait_done();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule